// File: doc/BRIEF.md
# Instruction Prefetch Controller

This block keeps a short queue of instruction words, three 16-bit stages by default, ahead of the instruction decoder. It asks the bus scheduler for one word at a time. The sequencer starts fetching by pulsing a start strobe with a byte address. After that, the block fetches a new word whenever the queue has room for one. Room opens up when the decoder reports that it has used words, either because an instruction has finished or because it has taken extension words.

Two conditions hold a request back. The first is a predecode flag that marks the next instruction as a change of flow, since the words after a jump or branch would be thrown away. The second is a busy flag for operand accesses, because operand cycles take priority on the bus. A new start strobe empties the queue and moves fetching to the new address. If a fetch is still on the bus at that moment, it runs to completion, but the word it returns is dropped. At most one fetch is on the bus at any time.

Top module: `pfetch_ctrl`

## Requirements
- R1: After reset, every stage is empty and `pf_req_o` stays low until the first `start_i` pulse.
- R2: In the cycle after `start_i`, `stage_valid_o` is all zero and `pf_addr_o` equals the `start_addr_i` that was sampled with the pulse. The first request accepted after the pulse carries that address.
- R3: Each accepted request (`pf_req_o` and `pf_gnt_i` both high) moves `pf_addr_o` up by 2 in the next cycle.
- R4: A request is raised only when no fetch is outstanding and the queue has a free stage after this cycle's consumption. A full queue that nothing consumes raises no request.
- R5: `pf_req_o` is low in every cycle in which `cof_next_i` is high.
- R6: `pf_req_o` is low in every cycle in which `opnd_busy_i` is high.
- R7: Words enter the queue in fetch order. Stage 0, in the least significant bits of `stage_word_o`, is the oldest word. `stage_valid_o` is always packed from bit 0 upward.
- R8: `consume_i` retires that many words from the head, and the rest move toward stage 0. A value larger than the number of valid stages retires only the valid words.
- R9: A word that returns for a request accepted before a `start_i` pulse is discarded. This includes a word that returns in the same cycle as the pulse.
- R10: `pf_req_o` is low in any cycle in which `start_i` is high.
- R11: When a word returns in the same cycle as a consumption, the queue shifts first and the new word is placed in the first stage left free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or redirect strobe; empties the queue |
| start_addr_i | input | ADDR_W | Byte address to fetch from after `start_i` |
| consume_i | input | CNT_W | Number of head words used this cycle |
| cof_next_i | input | 1 | Next instruction is predecoded as a change of flow |
| opnd_busy_i | input | 1 | Operand accesses are pending on the bus |
| pf_req_o | output | 1 | Prefetch request |
| pf_addr_o | output | ADDR_W | Prefetch byte address |
| pf_gnt_i | input | 1 | Bus accepts the request in this cycle |
| pf_rvalid_i | input | 1 | Fetched word is returned in this cycle |
| pf_rdata_i | input | WORD_W | Fetched word |
| stage_valid_o | output | NSTAGE | Valid flag for each stage |
| stage_word_o | output | NSTAGE*WORD_W | Stage contents, stage 0 in the low bits |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, a fetched word returns while the decoder is consuming words: the queue has to shift and append in one step. In the second pair, a start pulse arrives while a fetch is outstanding, and its word may come back in that very cycle: the word has to be dropped either way. Zero-latency returns are run against one-word-per-cycle consumption to produce the first case, and the bench counts how often both happen together. Redirects fired at random against varying bus latency produce the second. Both are judged by checking every word that leaves the head against the expected word sequence of the most recent start address.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;
  typedef enum logic [1:0] {
    PF_IDLE,   // not started yet
    PF_READY,  // nothing outstanding
    PF_WAIT,   // fetch outstanding, keep its word
    PF_DROP    // fetch outstanding, discard its word
  } pf_state_e;

  localparam int unsigned PF_STEP = 2;  // bytes per instruction word
endpackage

// File: rtl/pfetch_queue.sv
module pfetch_queue #(
  parameter int unsigned NSTAGE = 3,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = $clog2(NSTAGE + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              flush_i,
  input  logic [CNT_W-1:0]                  cons_i,
  input  logic                              push_i,
  input  logic [WORD_W-1:0]                 push_word_i,
  output logic [CNT_W-1:0]                  count_o,
  output logic [NSTAGE-1:0][WORD_W-1:0]     words_o
);
  logic [NSTAGE-1:0][WORD_W-1:0] data_q, data_d;
  logic [CNT_W-1:0]              cnt_q, cnt_d, base;

  // stages left after this cycle's consumption
  assign base = cnt_q - cons_i;

  always_comb begin
    data_d = data_q;
    for (int i = 0; i < NSTAGE; i++) begin
      for (int j = 0; j < NSTAGE; j++) begin
        if (j == i + int'(cons_i)) data_d[i] = data_q[j];
      end
      if (push_i && (CNT_W'(i) == base)) data_d[i] = push_word_i;
    end
    cnt_d = flush_i ? '0 : base + CNT_W'(push_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
    end
  end

  assign count_o = cnt_q;
  assign words_o = data_q;
endmodule

// File: rtl/pfetch_issue.sv
module pfetch_issue
  import pfetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              room_i,
  input  logic              hold_i,
  input  logic              gnt_i,
  input  logic              rvalid_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              push_o
);
  pf_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              outst;

  assign outst  = (state_q == PF_WAIT) || (state_q == PF_DROP);
  assign req_o  = (state_q == PF_READY) && !start_i && !hold_i && room_i;
  assign push_o = (state_q == PF_WAIT) && rvalid_i && !start_i;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    if (start_i) begin
      addr_d  = start_addr_i;
      // an in-flight fetch that has not returned yet becomes stale
      state_d = (outst && !rvalid_i) ? PF_DROP : PF_READY;
    end else begin
      unique case (state_q)
        PF_READY: if (req_o && gnt_i) begin
          state_d = PF_WAIT;
          addr_d  = addr_q + ADDR_W'(PF_STEP);
        end
        PF_WAIT, PF_DROP: if (rvalid_i) state_d = PF_READY;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PF_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/pfetch_ctrl.sv
module pfetch_ctrl #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned NSTAGE = 3,
  localparam int unsigned CNT_W = $clog2(NSTAGE + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [ADDR_W-1:0]        start_addr_i,
  input  logic [CNT_W-1:0]         consume_i,
  input  logic                     cof_next_i,
  input  logic                     opnd_busy_i,
  output logic                     pf_req_o,
  output logic [ADDR_W-1:0]        pf_addr_o,
  input  logic                     pf_gnt_i,
  input  logic                     pf_rvalid_i,
  input  logic [WORD_W-1:0]        pf_rdata_i,
  output logic [NSTAGE-1:0]        stage_valid_o,
  output logic [NSTAGE*WORD_W-1:0] stage_word_o
);
  logic [CNT_W-1:0]              cnt, cons_eff, left;
  logic [NSTAGE-1:0][WORD_W-1:0] words;
  logic                          room, push;

  // never retire more words than are present
  assign cons_eff = (consume_i > cnt) ? cnt : consume_i;
  assign left     = cnt - cons_eff;
  assign room     = int'(left) < NSTAGE;

  pfetch_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .room_i       (room),
    .hold_i       (cof_next_i | opnd_busy_i),
    .gnt_i        (pf_gnt_i),
    .rvalid_i     (pf_rvalid_i),
    .req_o        (pf_req_o),
    .addr_o       (pf_addr_o),
    .push_o       (push)
  );

  pfetch_queue #(.NSTAGE(NSTAGE), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (start_i),
    .cons_i      (cons_eff),
    .push_i      (push),
    .push_word_i (pf_rdata_i),
    .count_o     (cnt),
    .words_o     (words)
  );

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    assign stage_valid_o[g]                 = int'(cnt) > g;
    assign stage_word_o[g*WORD_W +: WORD_W] = words[g];
  end
endmodule

// File: rtl/pfetch_ctrl_chk.sv
module pfetch_ctrl_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned NSTAGE = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic              cof_next_i,
  input logic              opnd_busy_i,
  input logic              pf_req_o,
  input logic [ADDR_W-1:0] pf_addr_o,
  input logic              pf_gnt_i,
  input logic              pf_rvalid_i,
  input logic [NSTAGE-1:0] stage_valid_o
);
  logic            started_q, out_q;
  logic [NSTAGE:0] vplus;

  assign vplus = {1'b0, stage_valid_o} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      out_q     <= 1'b0;
    end else begin
      if (start_i) started_q <= 1'b1;
      if (pf_req_o && pf_gnt_i) out_q <= 1'b1;
      else if (pf_rvalid_i)     out_q <= 1'b0;
    end
  end

  AST_IDLE_UNTIL_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> !pf_req_o);  // R1
  AST_START_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> pf_addr_o == $past(start_addr_i));  // R2
  AST_START_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> stage_valid_o == '0);  // R2
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_req_o && pf_gnt_i) |=> pf_addr_o == $past(pf_addr_o) + ADDR_W'(2));  // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_req_o |-> !out_q);  // R4
  AST_NO_REQ_COF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cof_next_i |-> !pf_req_o);  // R5
  AST_NO_REQ_OPND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_busy_i |-> !pf_req_o);  // R6
  AST_VALID_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vplus[NSTAGE-1:0] & stage_valid_o) == '0);  // R7
  AST_NO_REQ_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !pf_req_o);  // R10
endmodule

bind pfetch_ctrl pfetch_ctrl_chk #(.ADDR_W(ADDR_W), .NSTAGE(NSTAGE)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .start_addr_i  (start_addr_i),
  .cof_next_i    (cof_next_i),
  .opnd_busy_i   (opnd_busy_i),
  .pf_req_o      (pf_req_o),
  .pf_addr_o     (pf_addr_o),
  .pf_gnt_i      (pf_gnt_i),
  .pf_rvalid_i   (pf_rvalid_i),
  .stage_valid_o (stage_valid_o)
);

// File: tb/pfetch_ctrl_bench.sv
`timescale 1ns/1ps
module pfetch_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] start_addr_i = '0;
  logic [1:0]  consume_i = '0;
  logic        cof_i = 1'b0, opnd_i = 1'b0;
  logic        pf_req_o, pf_gnt_i = 1'b0, pf_rvalid_i = 1'b0;
  logic [23:0] pf_addr_o;
  logic [15:0] pf_rdata_i = '0;
  logic [2:0]  stage_valid_o;
  logic [47:0] stage_word_o;

  int n_cmp = 0, n_bad = 0;
  int lat = 0, coinc = 0;
  bit gnt_en = 1'b1, gnt_rand = 1'b0, first = 1'b0, pend = 1'b0;
  int pend_cnt = 0;
  logic [23:0] pend_addr = '0, exp_addr = '0;
  logic [15:0] exp_q[$];
  string tag_s = "R7";

  always #2.5 clk = ~clk;

  pfetch_ctrl u_pfetch_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_addr_i(start_addr_i),
    .consume_i(consume_i), .cof_next_i(cof_i), .opnd_busy_i(opnd_i),
    .pf_req_o(pf_req_o), .pf_addr_o(pf_addr_o), .pf_gnt_i(pf_gnt_i),
    .pf_rvalid_i(pf_rvalid_i), .pf_rdata_i(pf_rdata_i),
    .stage_valid_o(stage_valid_o), .stage_word_o(stage_word_o)
  );

  function automatic logic [15:0] mem(input logic [23:0] a);
    return a[16:1] ^ 16'hC35A;
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // bus responder and request monitor, mid-cycle
  always @(negedge clk) begin
    bit was_pend;
    if (rst_ni) begin
      #1;
      was_pend    = pend;
      pf_rvalid_i = 1'b0;
      if (pend) begin
        if (pend_cnt == 0) begin
          pf_rvalid_i = 1'b1;
          pf_rdata_i  = mem(pend_addr);
          pend        = 1'b0;
          if (consume_i != 0 && stage_valid_o != 0) coinc++;
        end else pend_cnt--;
      end
      pf_gnt_i = gnt_en && (!gnt_rand || $urandom_range(0, 2) != 0);
      if (pf_req_o) chk(!was_pend, "R4", 32'(was_pend), 0);
      if (cof_i)    chk(!pf_req_o, "R5", 32'(pf_req_o), 0);
      if (opnd_i)   chk(!pf_req_o, "R6", 32'(pf_req_o), 0);
      if (start_i)  chk(!pf_req_o, "R10", 32'(pf_req_o), 0);
      if (pf_req_o && pf_gnt_i) begin
        chk(pf_addr_o == exp_addr, first ? "R2" : "R3", 32'(pf_addr_o), 32'(exp_addr));
        first     = 1'b0;
        exp_addr  = exp_addr + 24'd2;
        pend      = 1'b1;
        pend_cnt  = lat;
        pend_addr = pf_addr_o;
      end
    end
  end

  // driver: one cycle, consume k words, checking the head against the scoreboard
  task automatic step(input int k);
    int n, m;
    @(negedge clk);
    n = $countones(stage_valid_o);
    m = (k < n) ? k : n;
    for (int i = 0; i < m; i++) begin
      logic [15:0] w;
      if (exp_q.size() == 0) break;
      w = exp_q.pop_front();
      chk(stage_word_o[i*16 +: 16] == w, (k > n) ? "R8" : tag_s,
          32'(stage_word_o[i*16 +: 16]), 32'(w));
    end
    consume_i = 2'(k);
  endtask

  task automatic start_at(input logic [23:0] a);
    @(negedge clk);
    start_i      = 1'b1;
    start_addr_i = a;
    consume_i    = '0;
    exp_addr     = a;
    first        = 1'b1;
    exp_q.delete();
    for (int i = 0; i < 256; i++) exp_q.push_back(mem(a + 24'(2 * i)));
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk(stage_valid_o == 3'b000, "R2", 32'(stage_valid_o), 0);
    chk(pf_addr_o == a, "R2", 32'(pf_addr_o), 32'(a));
  endtask

  initial begin
    #50000;
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) step(0);
    #1;
    chk(stage_valid_o == 3'b000, "R1", 32'(stage_valid_o), 0);
    chk(!pf_req_o, "R1", 32'(pf_req_o), 0);

    start_at(24'h000100);
    repeat (12) step(0);
    #1;
    chk(stage_valid_o == 3'b111, "R4", 32'(stage_valid_o), 32'h7);
    chk(!pf_req_o, "R4", 32'(pf_req_o), 0);

    // zero-latency returns against steady consumption: R11
    repeat (16) step(1);
    repeat (8) begin step(2); step(0); end

    lat = 2; gnt_rand = 1'b1;
    for (int i = 0; i < 60; i++) step($urandom_range(0, 2));
    lat = 0; gnt_rand = 1'b0;
    repeat (12) step(0);

    // change of flow pending: no refill, and over-consumption: R5, R8
    cof_i = 1'b1;
    step(2);
    repeat (4) step(0);
    #1;
    chk($countones(stage_valid_o) == 1, "R8", 32'($countones(stage_valid_o)), 1);
    step(2);
    repeat (6) step(0);
    #1;
    chk(stage_valid_o == 3'b000, "R5", 32'(stage_valid_o), 0);
    cof_i = 1'b0;
    repeat (8) step(0);

    // operand accesses pending: R6
    opnd_i = 1'b1;
    step(3);
    repeat (6) step(0);
    #1;
    chk(stage_valid_o == 3'b000, "R6", 32'(stage_valid_o), 0);
    opnd_i = 1'b0;
    repeat (8) step(1);

    // redirect while a fetch is outstanding: R9
    tag_s = "R9";
    lat = 5;
    begin
      int g = 0;
      step(3);
      while (!pend && g < 20) begin step(0); g++; end
    end
    start_at(24'h002000);
    repeat (16) step(0);
    repeat (6) step(1);

    // random redirects against varying latency
    gnt_rand = 1'b1;
    for (int i = 0; i < 300; i++) begin
      lat = $urandom_range(0, 3);
      if ($urandom_range(0, 14) == 0) start_at(24'($urandom_range(0, 8191)) << 1);
      else step($urandom_range(0, 2));
    end

    chk(coinc > 0, "R11", 32'(coinc), 1);
    finish_run();
  end
endmodule